// File: doc/BRIEF.md
# Low-Power Stop Entry Sequencer

This block runs the bus handshake that announces a processor's entry into a low-power stop state. When the core asks to stop, the block captures the core's 3-bit interrupt mask and raises a bus request. It does not start anything on the bus until the shared bus is granted. It then drives a write cycle in CPU address space, of type 3, with the mask on the low data bits, so that devices outside the chip can see that the processor is about to stop.

The block ends the write with an acknowledge that it generates itself; no external device terminates the cycle. After the acknowledge it watches a hold-off input. While an external device keeps that input high, entry into the stop state waits. When the input is seen low, the block raises its stopped flag. It keeps that flag until a wake input returns it to idle. The clock gating and the wake-up sources belong to other blocks.

Top module: `lpstop_entry_seq`

## Requirements
- R1: During and after reset, busReqOut, asOut, dsOut, ackOut and stoppedOut are low, rwOut is high (read), and addrOut, fcOut and dataOut are zero.
- R2: In idle, a stopReq sampled high at a clock edge captures stopMask and raises busReqOut from the next cycle.
- R3: No bus cycle starts before busGrant is sampled high while busReqOut is high. asOut and dsOut rise on the cycle after that edge.
- R4: While the strobes are asserted, rwOut is low (write) and fcOut is 3'b111. addrOut carries the value 3 in bits 19 to 16, and all its other bits are zero.
- R5: While the strobes are asserted, dataOut bits 2 to 0 carry the captured mask with its most significant bit on bit 2, and bits 15 to 3 are zero. Outside the cycle, dataOut, addrOut and fcOut are zero.
- R6: The strobes stay asserted for CYC_WAIT cycles without acknowledge. Then ackOut is high for exactly one cycle with the strobes still asserted. The strobes drop after that cycle.
- R7: haltIn is sampled at the edge that ends the acknowledge cycle and at every edge after it. stoppedOut rises on the cycle after the first such edge that sees haltIn low, and stays low while haltIn is sampled high.
- R8: stoppedOut stays high until wakeIn is sampled high, which returns the block to idle on the next cycle. wakeIn has no effect in any other state.
- R9: stopReq and stopMask are ignored outside idle: a new request or mask change during a cycle or while stopped does not alter dataOut or the sequence.
- R10: busReqOut stays high from the request through the acknowledge cycle and drops on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stopReq | input | 1 | Core request to enter the stop state |
| stopMask | input | 3 | Core interrupt mask to announce |
| busGrant | input | 1 | Shared bus is available |
| haltIn | input | 1 | External hold-off; high delays stop entry |
| wakeIn | input | 1 | Clears the stopped state |
| busReqOut | output | 1 | Bus request |
| asOut | output | 1 | Address strobe |
| dsOut | output | 1 | Data strobe |
| rwOut | output | 1 | Direction, 1 read / 0 write |
| addrOut | output | ADDR_W | Address of the announcement cycle |
| fcOut | output | 3 | Function code |
| dataOut | output | DATA_W | Data carrying the mask |
| ackOut | output | 1 | Internally generated cycle acknowledge |
| stoppedOut | output | 1 | Stop state entered |

## Verification
The bound checker checks, on every cycle, the cycle encoding (write direction, function code, zero upper data bits). It also checks that the strobes only rise after a grant, that the acknowledge is a single pulse inside the strobes, that the stopped flag rises only after haltIn was low, and that the flag holds until wake. Other rules depend on history over several cycles: the exact count of wait cycles before the acknowledge, that the announced mask is the one captured in idle, and that requests and wakes in the wrong state are ignored. The bench shows these through its cycle-accurate expected-value model, driven by random request, grant, halt and wake patterns and by directed long-halt and late-request cases.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_CYC  = 3'd2,
    ST_ACK  = 3'd3,
    ST_HOLD = 3'd4,
    ST_STOP = 3'd5
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadMask;
    logic driveBus;
    logic ackPulse;
    logic holdBus;
    logic inStop;
  } ctlStrobe_t;

  localparam int MASK_W = 3;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;

endpackage

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
  import lpstop_pkg::*;
#(
  parameter int CYC_WAIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       busGrant,
  input  logic       haltIn,
  input  logic       wakeIn,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = (CYC_WAIT < 2) ? 1 : $clog2(CYC_WAIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_WAIT - 1);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (stopReq) stateNext = ST_REQ;
      ST_REQ:  if (busGrant) stateNext = ST_CYC;
      ST_CYC:  if (waitCnt == CNT_LAST) stateNext = ST_ACK;
      ST_ACK:  stateNext = haltIn ? ST_HOLD : ST_STOP;
      ST_HOLD: if (!haltIn) stateNext = ST_STOP;
      ST_STOP: if (wakeIn) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_CYC && stateNext == ST_CYC)
        waitCnt <= waitCnt + 1'b1;
      else
        waitCnt <= '0;
    end
  end

  always_comb begin
    ctl.loadMask = (state == ST_IDLE) && stopReq;
    ctl.driveBus = (state == ST_CYC) || (state == ST_ACK);
    ctl.ackPulse = (state == ST_ACK);
    ctl.holdBus  = (state == ST_REQ) || (state == ST_CYC) || (state == ST_ACK);
    ctl.inStop   = (state == ST_STOP);
  end

endmodule

// File: rtl/lpstop_dpath.sv
module lpstop_dpath
  import lpstop_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SPACE_TYPE = 3,
  parameter int SPACE_LSB  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [MASK_W-1:0] stopMask,
  output logic              busReqOut,
  output logic              asOut,
  output logic              dsOut,
  output logic              rwOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [2:0]        fcOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ackOut,
  output logic              stoppedOut
);

  localparam logic [ADDR_W-1:0] SPACE_ADDR = ADDR_W'(SPACE_TYPE) << SPACE_LSB;

  logic [MASK_W-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskReg <= '0;
    else if (ctl.loadMask) maskReg <= stopMask;
  end

  always_comb begin
    busReqOut  = ctl.holdBus;
    asOut      = ctl.driveBus;
    dsOut      = ctl.driveBus;
    rwOut      = !ctl.driveBus;
    addrOut    = ctl.driveBus ? SPACE_ADDR : '0;
    fcOut      = ctl.driveBus ? FC_CPU_SPACE : 3'b000;
    dataOut    = ctl.driveBus ? {{(DATA_W-MASK_W){1'b0}}, maskReg} : '0;
    ackOut     = ctl.ackPulse;
    stoppedOut = ctl.inStop;
  end

endmodule

// File: rtl/lpstop_entry_seq.sv
module lpstop_entry_seq
  import lpstop_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int CYC_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic [2:0]        stopMask,
  input  logic              busGrant,
  input  logic              haltIn,
  input  logic              wakeIn,
  output logic              busReqOut,
  output logic              asOut,
  output logic              dsOut,
  output logic              rwOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [2:0]        fcOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              ackOut,
  output logic              stoppedOut
);

  ctlStrobe_t ctl;

  lpstop_ctrl #(.CYC_WAIT(CYC_WAIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .busGrant(busGrant),
    .haltIn(haltIn), .wakeIn(wakeIn), .ctl(ctl)
  );

  lpstop_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stopMask(stopMask),
    .busReqOut(busReqOut), .asOut(asOut), .dsOut(dsOut), .rwOut(rwOut),
    .addrOut(addrOut), .fcOut(fcOut), .dataOut(dataOut),
    .ackOut(ackOut), .stoppedOut(stoppedOut)
  );

endmodule

// File: rtl/lpstop_entry_chk.sv
module lpstop_entry_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopReq,
  input logic [2:0]        stopMask,
  input logic              busGrant,
  input logic              haltIn,
  input logic              wakeIn,
  input logic              busReqOut,
  input logic              asOut,
  input logic              dsOut,
  input logic              rwOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic [2:0]        fcOut,
  input logic [DATA_W-1:0] dataOut,
  input logic              ackOut,
  input logic              stoppedOut
);

  // R3: strobes only rise after a grant seen while requesting
  p_grant_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asOut) |-> ($past(busGrant) && $past(busReqOut)));

  // R4: write with CPU-space function code during the cycle
  p_cycle_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    asOut |-> (!rwOut && fcOut == 3'b111 && dsOut));

  // R5: upper data bits are zero during the cycle
  p_data_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    asOut |-> (dataOut[DATA_W-1:3] == '0));

  // R6: acknowledge is a single pulse inside the strobes
  p_ack_in_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> asOut);
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> (!ackOut && !asOut));

  // R7: stopped only rises after haltIn was sampled low
  p_halt_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stoppedOut) |-> !$past(haltIn));

  // R8: stopped holds until wake
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stoppedOut && !wakeIn) |=> stoppedOut);

  // R10: bus request covers the whole cycle
  p_req_cover_r10: assert property (@(posedge clk) disable iff (!rstN)
    asOut |-> busReqOut);

endmodule

bind lpstop_entry_seq lpstop_entry_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/lpstop_entry_seq_tb.sv
module lpstop_entry_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CYC_WAIT = 2;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0;
  logic [2:0] stopMask = 3'd0;
  logic busGrant = 1'b0;
  logic haltIn = 1'b0;
  logic wakeIn = 1'b0;
  logic busReqOut, asOut, dsOut, rwOut, ackOut, stoppedOut;
  logic [ADDR_W-1:0] addrOut;
  logic [2:0] fcOut;
  logic [DATA_W-1:0] dataOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpstop_entry_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_WAIT(CYC_WAIT)) dut_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stopMask(stopMask),
    .busGrant(busGrant), .haltIn(haltIn), .wakeIn(wakeIn),
    .busReqOut(busReqOut), .asOut(asOut), .dsOut(dsOut), .rwOut(rwOut),
    .addrOut(addrOut), .fcOut(fcOut), .dataOut(dataOut),
    .ackOut(ackOut), .stoppedOut(stoppedOut)
  );

  // Reference model of the requirements: 0 idle, 1 request, 2 strobes,
  // 3 acknowledge, 4 hold-off, 5 stopped
  int mSt = 0;
  int mCnt = 0;
  logic [2:0] mMask = 3'd0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt <= 0; mCnt <= 0; mMask <= 3'd0;
    end else begin
      case (mSt)
        0: if (stopReq) begin mSt <= 1; mMask <= stopMask; end   // R2, R9
        1: if (busGrant) begin mSt <= 2; mCnt <= 0; end          // R3
        2: if (mCnt == CYC_WAIT-1) mSt <= 3; else mCnt <= mCnt + 1; // R6
        3: mSt <= haltIn ? 4 : 5;                                 // R7
        4: if (!haltIn) mSt <= 5;                                 // R7
        default: if (wakeIn) mSt <= 0;                            // R8
      endcase
    end
  end

  function automatic logic [ADDR_W-1:0] expAddr(int st);
    return (st == 2 || st == 3) ? (ADDR_W'(3) << 16) : '0;
  endfunction

  function automatic logic [DATA_W-1:0] expData(int st, logic [2:0] m);
    return (st == 2 || st == 3) ? {{(DATA_W-3){1'b0}}, m} : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit drive;
    drive = (mSt == 2 || mSt == 3);
    chk(busReqOut == (mSt >= 1 && mSt <= 3), "R10", "busReqOut", 32'(busReqOut), 32'(mSt >= 1 && mSt <= 3));
    chk(asOut == drive && dsOut == drive, "R3", "strobes", {30'd0, asOut, dsOut}, {30'd0, drive, drive});
    chk(rwOut == !drive, "R4", "rwOut", 32'(rwOut), 32'(!drive));
    chk(fcOut == (drive ? 3'b111 : 3'b000), "R4", "fcOut", 32'(fcOut), drive ? 32'd7 : 32'd0);
    chk(addrOut == expAddr(mSt), "R4", "addrOut", 32'(addrOut), 32'(expAddr(mSt)));
    chk(dataOut == expData(mSt, mMask), "R5", "dataOut", 32'(dataOut), 32'(expData(mSt, mMask)));
    chk(ackOut == (mSt == 3), "R6", "ackOut", 32'(ackOut), 32'(mSt == 3));
    chk(stoppedOut == (mSt == 5), "R7", "stoppedOut", 32'(stoppedOut), 32'(mSt == 5));
  endtask

  // one cycle: check outputs at negedge, then drive the next inputs
  task automatic step(input bit rq, input logic [2:0] mk, input bit gr,
                      input bit hl, input bit wk);
    @(negedge clk);
    checkAll();
    stopReq = rq; stopMask = mk; busGrant = gr; haltIn = hl; wakeIn = wk;
  endtask

  task automatic randPhase(input int n, input int pReq, input int pGr,
                           input int pHl, input int pWk);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pReq, 3'($urandom), ($urandom % 100) < pGr,
           ($urandom % 100) < pHl, ($urandom % 100) < pWk);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    chk(!busReqOut && !asOut && !dsOut && rwOut && !ackOut && !stoppedOut,
        "R1", "control in reset", {26'd0, busReqOut, asOut, dsOut, rwOut, ackOut, stoppedOut}, 32'h4);
    chk(addrOut == '0 && fcOut == '0 && dataOut == '0, "R1", "buses in reset",
        32'(dataOut), 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R2 R3 R4 R5 R6 directed: mask 3'b101, grant late, no halt
    step(1, 3'b101, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 3'b000, 0, 0, 0);   // R3 no grant
    step(0, 3'b010, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 3'b011, 0, 0, 0);  // R9 requests ignored
    step(0, 3'b000, 0, 0, 1);                               // R8 wake
    step(0, 3'b000, 0, 0, 0);

    // R7 directed: long halt after ack, then release
    step(1, 3'b100, 1, 1, 0);
    for (int i = 0; i < 12; i++) step(1, 3'b001, 1, 1, 0);
    step(0, 3'b000, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 3'b111, 1, 0, 0);  // R9 while stopped
    step(0, 3'b000, 0, 0, 1);                               // R8
    step(0, 3'b000, 0, 0, 0);

    // random phases
    randPhase(800, 40, 30, 30, 20);
    randPhase(800, 80, 10, 70, 10);
    randPhase(800, 20, 90, 10, 50);
    step(0, 3'b000, 0, 0, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule